// File: doc/BRIEF.md
# Root Power-Management Event Collector

This block sits at a root port and collects power-management event messages that arrive from devices below it. Each message carries a 16-bit requester ID. The input handshake is valid/ready in form, but ready is held high at all times. Messages that find no room are discarded instead of stalled, so a full collector can never hold up the message path. A sender whose request was discarded recovers by retrying after its own timeout, which lies outside this block.

The oldest outstanding request is shown in a root status register. This register holds a status bit, the requester ID and a sticky pending-overflow bit. Newer requests wait in a small first-in first-out buffer whose depth is a parameter. A level interrupt is raised while the status bit is set and interrupts are enabled. Software acknowledges a request by writing one to the status bit. If more requests are waiting, the next one is loaded, and the bit comes back one cycle after it was cleared.

Top module: `pme_root_collector`

## Requirements
- R1: A message accepted while the status bit is clear, no reload is pending and the buffer is empty appears on the next cycle as status bit 1 with `stat_id` equal to its requester ID. While the bit stays set and no acknowledge is written, `stat_id` does not change.
- R2: `irq` is 1 exactly when the status bit is 1 and `irq_en` is 1.
- R3: Beyond the request in the status register, the buffer holds DEPTH (default 4) pending requests, so at most DEPTH+1 are outstanding. A message arriving when all are occupied, with no acknowledge in the same cycle, is discarded and never appears in `stat_id`.
- R4: `msg_ready` is 1 in every cycle, including during reset.
- R5: A write of one on `ack_wr` while the status bit is 1 clears the bit on the next cycle. If requests are pending, the bit is set again on the cycle after that, with the next requester ID.
- R6: Requests are presented in the order in which they were accepted.
- R7: `stat_ovf` becomes 1 on the cycle after a message arrives while the status bit is 1 and the buffer is non-empty. It returns to 0 after an acknowledge that takes effect, unless a new setting arrival happens in the same cycle.
- R8: `ack_wr` while the status bit is 0 has no effect.
- R9: After reset, `stat_pme`, `stat_ovf` and `irq` are 0 and no request is outstanding.
- R10: A message arriving in the same cycle as an acknowledge that finds the buffer empty is kept. It is loaded and appears with the status bit after the one-cycle clear gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | A power-management message is offered this cycle |
| msg_id | input | ID_W | Requester ID of the offered message |
| msg_ready | output | 1 | Always 1: messages are never back-pressured |
| irq_en | input | 1 | Interrupt enable |
| ack_wr | input | 1 | Write-one pulse to the status bit |
| stat_pme | output | 1 | Status bit: a request is presented |
| stat_id | output | ID_W | Requester ID of the presented request |
| stat_ovf | output | 1 | Pending-overflow indication |
| irq | output | 1 | Level interrupt request |

## Verification
A corrupted buffer pointer or count shows at the ports within a few acknowledges. The symptom is a requester ID presented out of order, repeated or missing, or a status bit that fails to return after an acknowledge. A wrong reload flag shows one cycle after an acknowledge, as a bit that never reappears or one that skips its clear gap. A wrong full decision shows as a discarded request that appears anyway, or an accepted one that never appears. The bench models occupancy and order in a queue and compares each rising edge of the status bit against it. Because of that, these faults are reported at the first rising edge affected.

// File: rtl/pme_pkg.sv
package pme_pkg;

  // Decision taken by the status controller in one cycle
  typedef enum logic [2:0] {
    ACT_HOLD      = 3'd0,  // nothing changes in the status register
    ACT_DIRECT    = 3'd1,  // idle: load arriving message straight in
    ACT_ACK_POP   = 3'd2,  // acknowledge, next entry taken from buffer
    ACT_ACK_TAKE  = 3'd3,  // acknowledge, arriving message taken instead
    ACT_ACK_EMPTY = 3'd4,  // acknowledge, nothing left
    ACT_RELOAD    = 3'd5   // second half of a reload: raise the bit
  } pme_act_e;

  function automatic int unsigned cnt_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

  function automatic int unsigned ptr_width(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/pme_pending_fifo.sv
module pme_pending_fifo #(
  parameter int unsigned ID_W  = 16,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = pme_pkg::cnt_width(DEPTH),
  localparam int unsigned PTR_W = pme_pkg::ptr_width(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [ID_W-1:0]  push_id,
  input  logic             pop,
  output logic [ID_W-1:0]  head_id,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);

  localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ID_W-1:0]  slot_q [DEPTH];

  // Next-state: pointers wrap at DEPTH-1, count follows push/pop
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push) begin
      wr_ptr_d = (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop) begin
      rd_ptr_d = (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
    end
    unique case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // One storage register per entry, each with its own write enable
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = push && (wr_ptr_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) begin
        slot_q[g] <= push_id;
      end
    end
  end

  assign head_id = slot_q[rd_ptr_q];
  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign count   = cnt_q;

endmodule

// File: rtl/pme_status_ctrl.sv
module pme_status_ctrl #(
  parameter int unsigned ID_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            msg_valid,
  input  logic [ID_W-1:0] msg_id,
  input  logic            ack_wr,
  input  logic            buf_empty,
  input  logic            buf_full,
  input  logic [ID_W-1:0] buf_head,
  output logic            buf_push,
  output logic            buf_pop,
  output logic            stat_pme,
  output logic [ID_W-1:0] stat_id,
  output logic            stat_ovf,
  output logic            reload_pend
);

  import pme_pkg::*;

  logic            pme_q, pme_d;
  logic [ID_W-1:0] id_q, id_d;
  logic            id_en;
  logic            ovf_q, ovf_d;
  logic            rld_q, rld_d;
  logic            ack_eff;
  logic            ovf_set;
  pme_act_e        act;

  assign ack_eff = ack_wr && pme_q;
  assign ovf_set = msg_valid && pme_q && !buf_empty;

  // Decide what the status register does this cycle
  always_comb begin
    act = ACT_HOLD;
    if (ack_eff) begin
      if (!buf_empty)     act = ACT_ACK_POP;
      else if (msg_valid) act = ACT_ACK_TAKE;
      else                act = ACT_ACK_EMPTY;
    end else if (rld_q) begin
      act = ACT_RELOAD;
    end else if (!pme_q && buf_empty && msg_valid) begin
      act = ACT_DIRECT;
    end
  end

  // Next-state for status bit, ID, reload flag and buffer strobes
  always_comb begin
    pme_d    = pme_q;
    id_d     = id_q;
    id_en    = 1'b0;
    rld_d    = rld_q;
    buf_push = 1'b0;
    buf_pop  = 1'b0;
    unique case (act)
      ACT_DIRECT: begin
        pme_d = 1'b1;
        id_d  = msg_id;
        id_en = 1'b1;
      end
      ACT_ACK_POP: begin
        pme_d    = 1'b0;
        id_d     = buf_head;
        id_en    = 1'b1;
        rld_d    = 1'b1;
        buf_pop  = 1'b1;
        buf_push = msg_valid;  // the pop frees a slot this cycle
      end
      ACT_ACK_TAKE: begin
        pme_d = 1'b0;
        id_d  = msg_id;
        id_en = 1'b1;
        rld_d = 1'b1;
      end
      ACT_ACK_EMPTY: begin
        pme_d = 1'b0;
      end
      ACT_RELOAD: begin
        pme_d    = 1'b1;
        rld_d    = 1'b0;
        buf_push = msg_valid && !buf_full;
      end
      default: begin
        // status bit set and untouched: arrivals queue or drop
        buf_push = msg_valid && pme_q && !buf_full;
      end
    endcase
  end

  // Overflow indication: a setting arrival beats a clearing acknowledge
  always_comb begin
    ovf_d = ovf_q;
    if (ovf_set)      ovf_d = 1'b1;
    else if (ack_eff) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pme_q <= 1'b0;
      ovf_q <= 1'b0;
      rld_q <= 1'b0;
    end else begin
      pme_q <= pme_d;
      ovf_q <= ovf_d;
      rld_q <= rld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= '0;
    end else if (id_en) begin
      id_q <= id_d;
    end
  end

  assign stat_pme    = pme_q;
  assign stat_id     = id_q;
  assign stat_ovf    = ovf_q;
  assign reload_pend = rld_q;

endmodule

// File: rtl/pme_irq_gate.sv
module pme_irq_gate (
  input  logic stat_pme,
  input  logic irq_en,
  output logic irq
);

  assign irq = stat_pme & irq_en;

endmodule

// File: rtl/pme_root_collector.sv
module pme_root_collector #(
  parameter int unsigned ID_W  = 16,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = pme_pkg::cnt_width(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            msg_valid,
  input  logic [ID_W-1:0] msg_id,
  output logic            msg_ready,
  input  logic            irq_en,
  input  logic            ack_wr,
  output logic            stat_pme,
  output logic [ID_W-1:0] stat_id,
  output logic            stat_ovf,
  output logic            irq
);

  logic             buf_push;
  logic             buf_pop;
  logic [ID_W-1:0]  buf_head;
  logic             buf_empty;
  logic             buf_full;
  logic [CNT_W-1:0] fifo_count;
  logic             reload_pend;

  // Never back-pressure: a full buffer discards instead
  assign msg_ready = 1'b1;

  pme_pending_fifo #(
    .ID_W  (ID_W),
    .DEPTH (DEPTH)
  ) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (buf_push),
    .push_id (msg_id),
    .pop     (buf_pop),
    .head_id (buf_head),
    .empty   (buf_empty),
    .full    (buf_full),
    .count   (fifo_count)
  );

  pme_status_ctrl #(
    .ID_W (ID_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .msg_valid   (msg_valid),
    .msg_id      (msg_id),
    .ack_wr      (ack_wr),
    .buf_empty   (buf_empty),
    .buf_full    (buf_full),
    .buf_head    (buf_head),
    .buf_push    (buf_push),
    .buf_pop     (buf_pop),
    .stat_pme    (stat_pme),
    .stat_id     (stat_id),
    .stat_ovf    (stat_ovf),
    .reload_pend (reload_pend)
  );

  pme_irq_gate u_irq (
    .stat_pme (stat_pme),
    .irq_en   (irq_en),
    .irq      (irq)
  );

endmodule

// File: rtl/pme_root_collector_chk.sv
module pme_root_collector_chk #(
  parameter int unsigned ID_W  = 16,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = pme_pkg::cnt_width(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic [ID_W-1:0]  msg_id,
  input logic             msg_ready,
  input logic             irq_en,
  input logic             ack_wr,
  input logic             stat_pme,
  input logic [ID_W-1:0]  stat_id,
  input logic             stat_ovf,
  input logic             irq,
  input logic [CNT_W-1:0] fifo_count,
  input logic             reload_pend
);

  assert_direct_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !stat_pme && !reload_pend && fifo_count == '0)
      |=> (stat_pme && stat_id == $past(msg_id)));

  assert_id_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_pme && !ack_wr) |=> $stable(stat_id));

  assert_irq_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_pme && irq_en) |-> irq);

  assert_irq_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_pme |-> !irq);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH));

  assert_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ready);

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && stat_pme) |=> !stat_pme);

  assert_reload_returns_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && stat_pme && fifo_count != '0) |=> ##1 stat_pme);

  assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && stat_pme && fifo_count != '0) |=> stat_ovf);

  assert_idle_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !stat_pme && !reload_pend && !msg_valid && fifo_count == '0)
      |=> !stat_pme);

endmodule

bind pme_root_collector pme_root_collector_chk #(
  .ID_W  (ID_W),
  .DEPTH (DEPTH)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .msg_valid   (msg_valid),
  .msg_id      (msg_id),
  .msg_ready   (msg_ready),
  .irq_en      (irq_en),
  .ack_wr      (ack_wr),
  .stat_pme    (stat_pme),
  .stat_id     (stat_id),
  .stat_ovf    (stat_ovf),
  .irq         (irq),
  .fifo_count  (fifo_count),
  .reload_pend (reload_pend)
);

// File: tb/tb_pme_root_collector.sv
`timescale 1ns/1ps
module tb_pme_root_collector;

  localparam int unsigned ID_W  = 16;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned CAP   = DEPTH + 1;

  logic            clk;
  logic            rst_n;
  logic            msg_valid;
  logic [ID_W-1:0] msg_id;
  logic            msg_ready;
  logic            irq_en;
  logic            ack_wr;
  logic            stat_pme;
  logic [ID_W-1:0] stat_id;
  logic            stat_ovf;
  logic            irq;

  int checks;
  int failures;
  int outstanding;
  int drops;
  bit done;
  logic prev_pme;
  logic [ID_W-1:0] expq[$];

  pme_root_collector #(.ID_W(ID_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_id(msg_id),
    .msg_ready(msg_ready), .irq_en(irq_en), .ack_wr(ack_wr),
    .stat_pme(stat_pme), .stat_id(stat_id), .stat_ovf(stat_ovf), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle of stimulus at a negedge, update the model, wait a cycle
  task automatic step(input logic v, input logic [ID_W-1:0] id, input logic a);
    msg_valid = v;
    msg_id    = id;
    ack_wr    = a;
    if (a && stat_pme) outstanding--;
    if (v) begin
      if (outstanding < CAP) begin
        expq.push_back(id);
        outstanding++;
      end else begin
        drops++;
      end
    end
    @(negedge clk);
    msg_valid = 1'b0;
    ack_wr    = 1'b0;
  endtask

  // Monitor: each rising edge of the status bit must present the next expected ID
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_pme <= 1'b0;
    end else begin
      if (stat_pme && !prev_pme) begin
        if (expq.size() == 0) begin
          check(1'b0, "R3 unexpected request presented", int'(stat_id), 0);
        end else begin
          logic [ID_W-1:0] e;
          e = expq.pop_front();
          check(stat_id == e, "R6 order / R1 id", int'(stat_id), int'(e));
        end
      end
      prev_pme <= stat_pme;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; msg_valid = 1'b0; msg_id = '0; ack_wr = 1'b0; irq_en = 1'b0;
    checks = 0; failures = 0; outstanding = 0; drops = 0; done = 0;
    repeat (3) @(negedge clk);
    check(msg_ready == 1'b1, "R4 ready in reset", msg_ready, 1);
    check(stat_pme == 1'b0, "R9 status after reset", stat_pme, 0);
    check(stat_ovf == 1'b0, "R9 ovf after reset", stat_ovf, 0);
    check(irq == 1'b0, "R9 irq after reset", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2: direct load, interrupt gated by enable
    step(1'b1, 16'hA001, 1'b0);
    check(stat_pme == 1'b1, "R1 bit set next cycle", stat_pme, 1);
    check(stat_id == 16'hA001, "R1 id latched", int'(stat_id), 16'hA001);
    check(irq == 1'b0, "R2 irq masked", irq, 0);
    irq_en = 1'b1;
    #1;
    check(irq == 1'b1, "R2 irq enabled", irq, 1);
    check(msg_ready == 1'b1, "R4 ready", msg_ready, 1);

    // R5: acknowledge with nothing pending
    step(1'b0, '0, 1'b1);
    check(stat_pme == 1'b0, "R5 ack clears", stat_pme, 0);
    check(irq == 1'b0, "R2 irq drops with bit", irq, 0);
    step(1'b0, '0, 1'b0);
    check(stat_pme == 1'b0, "R5 stays clear when empty", stat_pme, 0);

    // R8: acknowledge while clear is ignored
    step(1'b0, '0, 1'b1);
    check(stat_pme == 1'b0, "R8 idle ack no effect", stat_pme, 0);
    step(1'b1, 16'hB000, 1'b0);
    check(stat_id == 16'hB000, "R8 later load normal", int'(stat_id), 16'hB000);

    // R3/R7: burst into the buffer, overflow indication, drops when full
    step(1'b1, 16'hB001, 1'b0);
    check(stat_ovf == 1'b0, "R7 no ovf with empty buffer", stat_ovf, 0);
    for (int i = 2; i <= 6; i++) step(1'b1, 16'hB000 + 16'(i), 1'b0);
    check(stat_ovf == 1'b1, "R7 ovf set", stat_ovf, 1);
    check(drops == 2, "R3 two dropped when full", drops, 2);
    check(stat_id == 16'hB000, "R1 id stable while set", int'(stat_id), 16'hB000);

    // R5/R6: drain, each reload shows a one-cycle gap
    for (int k = 0; k < 5; k++) begin
      step(1'b0, '0, 1'b1);
      check(stat_pme == 1'b0, "R5 gap after ack", stat_pme, 0);
      if (k == 0) check(stat_ovf == 1'b0, "R7 ovf cleared by ack", stat_ovf, 0);
      step(1'b0, '0, 1'b0);
      check(stat_pme == (k < 4), "R5 bit returns if pending", stat_pme, (k < 4));
    end
    check(expq.size() == 0, "R3 dropped never presented", expq.size(), 0);

    // R10: message with acknowledge, buffer empty
    step(1'b1, 16'hC000, 1'b0);
    step(1'b1, 16'hC001, 1'b1);
    check(stat_pme == 1'b0, "R10 gap", stat_pme, 0);
    step(1'b0, '0, 1'b0);
    check(stat_pme == 1'b1 && stat_id == 16'hC001, "R10 kept", int'(stat_id), 16'hC001);
    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b0);

    // R3: acknowledge frees a slot for a same-cycle arrival when full
    for (int i = 0; i < 5; i++) step(1'b1, 16'hD000 + 16'(i), 1'b0);
    step(1'b1, 16'hD005, 1'b1);
    for (int k = 0; k < 12 && (stat_pme || expq.size() != 0); k++) begin
      step(1'b0, '0, stat_pme);
    end
    check(expq.size() == 0, "R6 all accepted presented", expq.size(), 0);
    check(stat_pme == 1'b0, "R5 empty at end", stat_pme, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule